// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional data buses, A and B, and passes data between them without inversion. It also keeps two storage registers. One holds a snapshot of bus A and the other holds a snapshot of bus B. Each register loads when its own capture strobe falls.

An active-low enable and a direction input decide which bus the block drives, if any. A per-direction source select then decides what goes onto the driven bus: the live value from the opposite bus, or the stored snapshot of that bus.

Each bus is presented as a separate input, output and output-enable, so a pad ring or tristate wrapper can be added outside the block. The capture strobes are sampled on the system clock. A strobe edge from high to low causes a load at the clock edge where the low level is first seen. Loading never depends on the enable, the direction or the selects, so A data and B data can be parked in the two registers while both buses float.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While `rst` is high, `a_drive` and `b_drive` are 0. A clock edge with `rst` high clears both storage registers to zero.
- R2: With `oe_n`=1 neither bus is driven. With `oe_n`=0 and `dir_a2b`=1 only `b_drive` is 1. With `oe_n`=0 and `dir_a2b`=0 only `a_drive` is 1.
- R3: `a_drive` and `b_drive` are never 1 at the same time.
- R4: While B is driven, `b_out` equals the live `a_in` when `sel_b_stored`=0, and equals the A-side register when `sel_b_stored`=1.
- R5: While A is driven, `a_out` equals the live `b_in` when `sel_a_stored`=0, and equals the B-side register when `sel_a_stored`=1.
- R6: Whenever a bus is not driven, its output data (`a_out` or `b_out`) reads all zeros.
- R7: The A-side register loads `a_in` at a clock edge where `cap_a` is 0 and `cap_a` was 1 at the previous edge. Rising edges and steady levels of `cap_a` leave the register unchanged.
- R8: The B-side register loads `b_in` under the same falling-strobe rule using `cap_b`, and holds otherwise.
- R9: Loads take place whatever the values of `oe_n`, `dir_a2b` and the selects. A load into one register leaves the other register unchanged.
- R10: A newly loaded value appears on the driven bus right after the capturing clock edge, with no added cycle, because the outputs are combinational from the inputs and the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Value seen on bus A |
| b_in | input | WIDTH | Value seen on bus B |
| oe_n | input | 1 | Active-low transceiver enable |
| dir_a2b | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_b_stored | input | 1 | Source for B: 0 live A, 1 A-side register |
| sel_a_stored | input | 1 | Source for A: 0 live B, 1 B-side register |
| cap_a | input | 1 | A-side capture strobe, loads on its falling edge |
| cap_b | input | 1 | B-side capture strobe, loads on its falling edge |
| a_out | output | WIDTH | Data to drive onto bus A |
| a_drive | output | 1 | Output enable for bus A |
| b_out | output | WIDTH | Data to drive onto bus B |
| b_drive | output | 1 | Output enable for bus B |

## Verification
The bench builds the block with WIDTH=4. At that width every pair of A and B register values, all 256 of them, can be loaded, and each pair is checked against all 16 combinations of enable, direction and the two selects. The live bus values are held distinct from the stored values, so a wrong source shows up as a wrong value. Directed sequences then cover rising edges and held levels of the strobes, single-register loads, and a reset taken after loads.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  typedef struct packed {
    logic a_en;
    logic b_en;
  } drive_t;

endpackage

// File: rtl/fall_detect.sv
module fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= strobe;
  end

  assign fall = prev_q & ~strobe;

  // R7/R8: two falling edges cannot follow on consecutive clocks
  a_r7_no_double_fall: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);

endmodule

// File: rtl/store_reg.sv
module store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)       q_r <= '0;
    else if (load) q_r <= d;
  end

  assign q = q_r;

  a_r7_load_takes_data: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));

  a_r9_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

endmodule

// File: rtl/lane_route.sv
module lane_route #(
  parameter int WIDTH = 8
) (
  input  logic             drive,
  input  xcvr_pkg::src_e   src,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out
);

  import xcvr_pkg::*;

  logic [WIDTH-1:0] picked;

  always_comb begin
    unique case (src)
      SRC_STORED: picked = stored;
      default:    picked = live;
    endcase
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign out[i] = drive & picked[i];
  end

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl (
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir_a2b,
  output xcvr_pkg::drive_t en
);

  logic active;

  assign active  = ~rst & ~oe_n;
  assign en.b_en = active & dir_a2b;
  assign en.a_en = active & ~dir_a2b;

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             oe_n,
  input  logic             dir_a2b,
  input  logic             sel_b_stored,
  input  logic             sel_a_stored,
  input  logic             cap_a,
  input  logic             cap_b,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive
);

  import xcvr_pkg::*;

  logic             fall_a, fall_b;
  logic [WIDTH-1:0] snap_a, snap_b;
  drive_t           en;

  fall_detect u_fall_a (.clk(clk), .rst(rst), .strobe(cap_a), .fall(fall_a));
  fall_detect u_fall_b (.clk(clk), .rst(rst), .strobe(cap_b), .fall(fall_b));

  store_reg #(.WIDTH(WIDTH)) u_snap_a (
    .clk(clk), .rst(rst), .load(fall_a), .d(a_in), .q(snap_a));
  store_reg #(.WIDTH(WIDTH)) u_snap_b (
    .clk(clk), .rst(rst), .load(fall_b), .d(b_in), .q(snap_b));

  dir_ctrl u_dir (.rst(rst), .oe_n(oe_n), .dir_a2b(dir_a2b), .en(en));

  lane_route #(.WIDTH(WIDTH)) u_to_b (
    .drive(en.b_en), .src(src_e'(sel_b_stored)),
    .live(a_in), .stored(snap_a), .out(b_out));
  lane_route #(.WIDTH(WIDTH)) u_to_a (
    .drive(en.a_en), .src(src_e'(sel_a_stored)),
    .live(b_in), .stored(snap_b), .out(a_out));

  assign a_drive = en.a_en;
  assign b_drive = en.b_en;

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!a_drive && !b_drive));

  a_r3_one_driver: assert property (@(posedge clk) disable iff (rst)
    !(a_drive && b_drive));

  a_r2_float_when_off: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_drive && !b_drive));

  a_r4_live_to_b: assert property (@(posedge clk) disable iff (rst)
    (b_drive && !sel_b_stored) |-> b_out == a_in);

  a_r5_live_to_a: assert property (@(posedge clk) disable iff (rst)
    (a_drive && !sel_a_stored) |-> a_out == b_in);

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!a_drive |-> a_out == '0) and (!b_drive |-> b_out == '0));

endmodule

// File: tb/reg_bus_xcvr_test.sv
`timescale 1ns/1ps
module reg_bus_xcvr_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         oe_n, dir_a2b, sel_b_stored, sel_a_stored, cap_a, cap_b;
  logic         a_drive, b_drive;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mra, mrb;

  always #2 clk = ~clk;

  reg_bus_xcvr #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .oe_n(oe_n),
    .dir_a2b(dir_a2b), .sel_b_stored(sel_b_stored), .sel_a_stored(sel_a_stored),
    .cap_a(cap_a), .cap_b(cap_b), .a_out(a_out), .a_drive(a_drive),
    .b_out(b_out), .b_drive(b_drive));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(string req);
    logic         ea, eb;
    logic [W-1:0] eao, ebo;
    ea  = !rst && !oe_n && !dir_a2b;
    eb  = !rst && !oe_n && dir_a2b;
    eao = ea ? (sel_a_stored ? mrb : b_in) : '0;
    ebo = eb ? (sel_b_stored ? mra : a_in) : '0;
    checks++;
    if (a_drive !== ea || b_drive !== eb || a_out !== eao || b_out !== ebo) begin
      errors++;
      $display("FAIL %s: got a_drv=%0b b_drv=%0b a_out=%h b_out=%h, expected %0b %0b %h %h",
               req, a_drive, b_drive, a_out, b_out, ea, eb, eao, ebo);
    end
  endtask

  task automatic set_ctl(int c);
    oe_n         = c[0];
    dir_a2b      = c[1];
    sel_b_stored = c[2];
    sel_a_stored = c[3];
  endtask

  task automatic pulse_a(logic [W-1:0] v);
    a_in = v; cap_a = 1'b1; tick();
    cap_a = 1'b0; tick();
    mra = v;
  endtask

  task automatic pulse_b(logic [W-1:0] v);
    b_in = v; cap_b = 1'b1; tick();
    cap_b = 1'b0; tick();
    mrb = v;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0; cap_a = 1'b0; cap_b = 1'b0;
    mra = '0; mrb = '0;
    set_ctl(4'b0110);
    tick(); tick();
    check_all("R1 drives off in reset");
    rst = 1'b0;
    #1;
    check_all("R1 registers zero after reset");
    set_ctl(4'b1100);
    #1;
    check_all("R1 B register zero after reset");

    // Full sweep of stored pairs against every control combination
    for (int av = 0; av < 16; av++) begin
      for (int bv = 0; bv < 16; bv++) begin
        set_ctl((av + bv) % 16);
        oe_n = 1'b1;  // R9: loads while both buses float
        a_in = W'(av); b_in = W'(bv);
        cap_a = 1'b1; cap_b = 1'b1; tick();
        cap_a = 1'b0; cap_b = 1'b0; tick();
        mra = W'(av); mrb = W'(bv);
        a_in = W'(av) ^ 4'hA;
        b_in = W'(bv) ^ 4'h3;
        for (int c = 0; c < 16; c++) begin
          set_ctl(c);
          #1;
          check_all("R2/R4/R5/R6/R8 sweep");
          if (a_drive && b_drive) begin
            errors++;
            $display("FAIL R3: got both drives 1, expected at most one");
          end
        end
      end
    end

    // R7: rising edge and held levels do not load
    pulse_a(4'h3);
    set_ctl(4'b0110);
    a_in = 4'h9; tick();
    cap_a = 1'b1; tick();
    check_all("R7 rising edge keeps A register");
    a_in = 4'hC; tick();
    check_all("R7 held high keeps A register");
    cap_a = 1'b0; tick();
    mra = 4'hC;
    check_all("R10 falling edge visible at once on B");
    a_in = 4'h5; tick(); tick();
    check_all("R7 held low keeps A register");

    // R8: B register strobe rules
    set_ctl(4'b1000);
    pulse_b(4'h6);
    b_in = 4'h1; cap_b = 1'b1; tick();
    check_all("R8 rising edge keeps B register");
    cap_b = 1'b0; tick();
    mrb = 4'h1;
    check_all("R8 falling edge loads B register");

    // R9: a load into A leaves B alone, while driving
    set_ctl(4'b1000);
    pulse_a(4'hE);
    check_all("R9 B register unchanged by A load");
    set_ctl(4'b0110);
    #1;
    check_all("R9 A register loaded while B driven");

    // R1: reset after loads clears both registers
    rst = 1'b1; tick();
    check_all("R1 drives off during reset");
    rst = 1'b0; mra = '0; mrb = '0;
    #1;
    check_all("R1 A register cleared");
    set_ctl(4'b1100);
    #1;
    check_all("R1 B register cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule